// File: doc/BRIEF.md
# Register Rename Table with Buffer-Ready Tracking

This block is the rename table of an out-of-order core that keeps speculative results in a reorder buffer. It holds one entry for each architectural register. An entry records the tag of the in-flight instruction that will write the register, and one bit that says whether that result already sits in the reorder buffer. Each cycle, dispatch looks up two source registers. For each source the block reports where the operand comes from: the committed register file, a tag to wait on, or a finished value to read out of the reorder buffer.

In the same cycle, dispatch may rename one destination register to a new tag. A completion port marks a tag's result as present in the buffer. A retire port returns a register to the register file. Both updates act only on an entry that still names their tag, so an older instruction cannot disturb a register that a younger one has renamed since. A flush returns every register to the register file, for recovery after a fault or mispredict. The register file and the reorder buffer storage sit outside this block.

Top module: `rat_ready_table`

## Requirements
- R1: Each source lookup returns a 2-bit kind and a tag. Kind 0 means the operand is in the register file (the entry's tag is 0, and the tag output is 0). Kind 1 means the operand is pending under the returned nonzero tag. Kind 2 means the operand is ready in the reorder buffer under the returned nonzero tag.
- R2: A dispatch writes the destination entry with the dispatch tag and clears its ready bit. From the next cycle, lookups of that register report kind 1 with that tag, provided the tag is nonzero.
- R3: Source lookups in a cycle see the table as it was before that cycle's dispatch write.
- R4: A completion sets the ready bit of an entry only when the entry holds the completing tag. A completion of a tag that no entry holds changes no lookup result.
- R5: A source lookup of an entry whose tag is completing in the same cycle already reports kind 2.
- R6: A retire clears an entry to tag 0 only when the entry holds the retiring tag. Otherwise the entry is left as it was.
- R7: A flush returns every entry to tag 0 on the next cycle. It takes priority over a dispatch, completion or retire in the same cycle.
- R8: When a dispatch renames a register in the same cycle that a completion or retire matches that register's old tag, the dispatch result is kept.
- R9: After reset, every register reports kind 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Return every register to the register file |
| disp_en | input | 1 | Rename the destination register this cycle |
| disp_dst | input | 3 | Destination architectural register |
| disp_tag | input | 4 | New producer tag for the destination |
| src0_reg | input | 3 | First source register |
| src1_reg | input | 3 | Second source register |
| src0_kind | output | 2 | Operand source of the first source (0 regfile, 1 pending, 2 in buffer) |
| src0_tag | output | 4 | Producer tag of the first source |
| src1_kind | output | 2 | Operand source of the second source |
| src1_tag | output | 4 | Producer tag of the second source |
| cmpl_en | input | 1 | A result completes this cycle |
| cmpl_tag | input | 4 | Tag of the completing result |
| ret_en | input | 1 | An instruction retires this cycle |
| ret_tag | input | 4 | Tag of the retiring instruction |

## Verification
The bench uses the default build: 8 architectural registers and 4-bit tags. With these values, a pseudo-random run of a few thousand cycles reaches every register and tag many times. It also produces frequent tag aliasing, where a stale completion or retire names a tag that is still live elsewhere or that was just renamed over. It also hits same-cycle collisions of dispatch, completion, retire and flush on one register. Directed sequences pin down the bypass, the ordering of lookups against the rename, and the priority between updates.

// File: rtl/rat_pkg.sv
package rat_pkg;
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'd0,
        SRC_PENDING = 2'd1,
        SRC_INBUF   = 2'd2
    } src_kind_e;
endpackage

// File: rtl/rat_entry_next.sv
module rat_entry_next #(
    parameter int TAG_W  = 4,
    parameter int IDX_W  = 3,
    parameter int MY_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] cur_tag,
    input  logic             cur_rdy,
    input  logic             flush,
    input  logic             disp_en,
    input  logic [IDX_W-1:0] disp_dst,
    input  logic [TAG_W-1:0] disp_tag,
    input  logic             cmpl_en,
    input  logic [TAG_W-1:0] cmpl_tag,
    input  logic             ret_en,
    input  logic [TAG_W-1:0] ret_tag,
    output logic [TAG_W-1:0] nxt_tag,
    output logic             nxt_rdy
);
    localparam logic [IDX_W-1:0] SELF = IDX_W'(MY_IDX);

    logic hit_disp, hit_cmpl, hit_ret, live;

    always_comb begin
        live     = (cur_tag != '0);
        hit_disp = disp_en && (disp_dst == SELF);
        hit_cmpl = cmpl_en && live && (cmpl_tag == cur_tag);
        hit_ret  = ret_en && live && (ret_tag == cur_tag);
        nxt_tag  = cur_tag;
        nxt_rdy  = cur_rdy;
        if (flush) begin
            nxt_tag = '0;
            nxt_rdy = 1'b0;
        end else if (hit_disp) begin
            nxt_tag = disp_tag;
            nxt_rdy = 1'b0;
        end else if (hit_ret) begin
            nxt_tag = '0;
            nxt_rdy = 1'b0;
        end else if (hit_cmpl) begin
            nxt_rdy = 1'b1;
        end
    end

    // R6: a retire that names this entry's live tag empties it on the next cycle
    a_r6_retire_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && live && ret_tag == cur_tag && !flush && !hit_disp) |=> (cur_tag == '0));

    // R4: an untouched entry keeps its ready bit when the completing tag differs
    a_r4_stale_cmpl: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !hit_disp && !hit_ret && !(cmpl_en && cmpl_tag == cur_tag))
        |=> $stable(cur_rdy));
endmodule

// File: rtl/rat_src_lookup.sv
module rat_src_lookup
    import rat_pkg::*;
#(
    parameter int NUM_ARCH = 8,
    parameter int TAG_W    = 4,
    parameter int IDX_W    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_ARCH*TAG_W-1:0] tags_flat,
    input  logic [NUM_ARCH-1:0]       rdys,
    input  logic [IDX_W-1:0]          sel,
    input  logic                      cmpl_en,
    input  logic [TAG_W-1:0]          cmpl_tag,
    output logic [1:0]                kind,
    output logic [TAG_W-1:0]          tag
);
    logic [TAG_W-1:0] ent_tag;
    logic             ent_rdy;
    logic             bypass;

    always_comb begin
        ent_tag = tags_flat[sel*TAG_W +: TAG_W];
        ent_rdy = rdys[sel];
        bypass  = cmpl_en && (cmpl_tag == ent_tag);
        tag     = ent_tag;
        if (ent_tag == '0)
            kind = SRC_REGFILE;
        else if (ent_rdy || bypass)
            kind = SRC_INBUF;
        else
            kind = SRC_PENDING;
    end

    // R1: a non-regfile answer always carries a nonzero tag, and kind 3 never appears
    a_r1_kind_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != SRC_REGFILE) |-> (tag != '0));
    a_r1_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
        kind != 2'd3);
    // R5: the completing tag is never reported as still pending
    a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_en && tag == cmpl_tag && tag != '0) |-> (kind == SRC_INBUF));
endmodule

// File: rtl/rat_ready_table.sv
module rat_ready_table
    import rat_pkg::*;
#(
    parameter int NUM_ARCH = 8,
    parameter int TAG_W    = 4,
    localparam int IDX_W   = $clog2(NUM_ARCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             disp_en,
    input  logic [IDX_W-1:0] disp_dst,
    input  logic [TAG_W-1:0] disp_tag,
    input  logic [IDX_W-1:0] src0_reg,
    input  logic [IDX_W-1:0] src1_reg,
    output logic [1:0]       src0_kind,
    output logic [TAG_W-1:0] src0_tag,
    output logic [1:0]       src1_kind,
    output logic [TAG_W-1:0] src1_tag,
    input  logic             cmpl_en,
    input  logic [TAG_W-1:0] cmpl_tag,
    input  logic             ret_en,
    input  logic [TAG_W-1:0] ret_tag
);
    typedef struct packed {
        logic [NUM_ARCH*TAG_W-1:0] tags;
        logic [NUM_ARCH-1:0]       rdys;
    } table_t;

    table_t table_d, table_q;
    logic [NUM_ARCH*TAG_W-1:0] nxt_tags;
    logic [NUM_ARCH-1:0]       nxt_rdys;

    for (genvar i = 0; i < NUM_ARCH; i++) begin : g_ent
        rat_entry_next #(.TAG_W(TAG_W), .IDX_W(IDX_W), .MY_IDX(i)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .cur_tag  (table_q.tags[i*TAG_W +: TAG_W]),
            .cur_rdy  (table_q.rdys[i]),
            .flush    (flush),
            .disp_en  (disp_en),
            .disp_dst (disp_dst),
            .disp_tag (disp_tag),
            .cmpl_en  (cmpl_en),
            .cmpl_tag (cmpl_tag),
            .ret_en   (ret_en),
            .ret_tag  (ret_tag),
            .nxt_tag  (nxt_tags[i*TAG_W +: TAG_W]),
            .nxt_rdy  (nxt_rdys[i])
        );
    end

    always_comb begin
        table_d.tags = nxt_tags;
        table_d.rdys = nxt_rdys;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) table_q <= '0;
        else        table_q <= table_d;
    end

    rat_src_lookup #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_rd0 (
        .clk(clk), .rst_n(rst_n),
        .tags_flat(table_q.tags), .rdys(table_q.rdys), .sel(src0_reg),
        .cmpl_en(cmpl_en), .cmpl_tag(cmpl_tag),
        .kind(src0_kind), .tag(src0_tag)
    );

    rat_src_lookup #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_rd1 (
        .clk(clk), .rst_n(rst_n),
        .tags_flat(table_q.tags), .rdys(table_q.rdys), .sel(src1_reg),
        .cmpl_en(cmpl_en), .cmpl_tag(cmpl_tag),
        .kind(src1_kind), .tag(src1_tag)
    );

    // R2 and R8: a dispatch lands with its tag and a cleared ready bit, whatever else hits that entry
    a_r2_disp_write: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en && !flush) |=>
        (table_q.tags[$past(disp_dst)*TAG_W +: TAG_W] == $past(disp_tag)
         && !table_q.rdys[$past(disp_dst)]));
    // R7: after a flush both lookups answer from the register file
    a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (src0_kind == SRC_REGFILE && src1_kind == SRC_REGFILE));
endmodule

// File: tb/sim_rat_ready_table.sv
module sim_rat_ready_table;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 0, disp_en = 0, cmpl_en = 0, ret_en = 0;
    logic [2:0] disp_dst = 0, src0_reg = 0, src1_reg = 0;
    logic [3:0] disp_tag = 0, cmpl_tag = 0, ret_tag = 0;
    logic [1:0] src0_kind, src1_kind;
    logic [3:0] src0_tag, src1_tag;

    int checks = 0, failures = 0;
    bit done = 0;
    int mt [8];
    bit mr [8];

    always #4 clk = ~clk;

    rat_ready_table u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .disp_en(disp_en), .disp_dst(disp_dst), .disp_tag(disp_tag),
        .src0_reg(src0_reg), .src1_reg(src1_reg),
        .src0_kind(src0_kind), .src0_tag(src0_tag),
        .src1_kind(src1_kind), .src1_tag(src1_tag),
        .cmpl_en(cmpl_en), .cmpl_tag(cmpl_tag),
        .ret_en(ret_en), .ret_tag(ret_tag)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_kind(int r);
        if (mt[r] == 0) return 0;
        if (mr[r] || (cmpl_en && int'(cmpl_tag) == mt[r])) return 2;
        return 1;
    endfunction

    task automatic step(string req, bit fl, bit de, int dd, int dt,
                        int s0, int s1, bit ce, int ct, bit re, int rt);
        @(negedge clk);
        flush = fl; disp_en = de; disp_dst = 3'(dd); disp_tag = 4'(dt);
        src0_reg = 3'(s0); src1_reg = 3'(s1);
        cmpl_en = ce; cmpl_tag = 4'(ct); ret_en = re; ret_tag = 4'(rt);
        #1;
        chk({req, " src0 kind"}, int'(src0_kind), exp_kind(s0));
        chk({req, " src0 tag"}, int'(src0_tag), mt[s0]);
        chk({req, " src1 kind"}, int'(src1_kind), exp_kind(s1));
        chk({req, " src1 tag"}, int'(src1_tag), mt[s1]);
        @(posedge clk);
        for (int i = 0; i < 8; i++) begin
            if (fl) begin
                mt[i] = 0; mr[i] = 0;
            end else if (de && dd == i) begin
                mt[i] = dt; mr[i] = 0;
            end else if (re && rt != 0 && mt[i] == rt) begin
                mt[i] = 0; mr[i] = 0;
            end else if (ce && ct != 0 && mt[i] == ct) begin
                mr[i] = 1;
            end
        end
    endtask

    task automatic idle_read(string req, int s0, int s1);
        step(req, 0, 0, 0, 0, s0, s1, 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < 8; i++) begin mt[i] = 0; mr[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R9: reset state for every register
        for (int i = 0; i < 8; i += 2) idle_read("R9", i, i + 1);
        // R3 then R2: lookup sees the old mapping, next cycle the rename
        step("R3", 0, 1, 3, 5, 3, 3, 0, 0, 0, 0);
        idle_read("R2", 3, 0);
        chk("R2 pending kind", int'(src0_kind), 1);
        // R5: bypass of a same-cycle completion, then R4 stored ready
        step("R5", 0, 0, 0, 0, 3, 2, 1, 5, 0, 0);
        idle_read("R4", 3, 3);
        chk("R4 ready kind", int'(src0_kind), 2);
        // R4: stale completion after a newer rename
        step("R2", 0, 1, 3, 6, 3, 1, 0, 0, 0, 0);
        step("R4", 0, 0, 0, 0, 3, 3, 1, 5, 0, 0);
        idle_read("R4", 3, 3);
        chk("R4 stale kind", int'(src0_kind), 1);
        // R6: stale retire leaves the entry, matching retire clears it
        step("R6", 0, 0, 0, 0, 3, 3, 0, 0, 1, 5);
        idle_read("R6", 3, 3);
        chk("R6 stale tag", int'(src0_tag), 6);
        step("R6", 0, 0, 0, 0, 3, 3, 1, 6, 1, 6);
        idle_read("R6", 3, 3);
        chk("R6 cleared kind", int'(src0_kind), 0);
        // R8: rename beats completion and retire of the old tag
        step("R2", 0, 1, 2, 7, 2, 2, 0, 0, 0, 0);
        step("R8", 0, 1, 2, 9, 2, 2, 1, 7, 0, 0);
        idle_read("R8", 2, 2);
        chk("R8 tag", int'(src0_tag), 9);
        step("R8", 0, 1, 2, 10, 2, 2, 0, 0, 1, 9);
        idle_read("R8", 2, 2);
        chk("R8 kind", int'(src0_kind), 1);
        // R7: flush beats a same-cycle dispatch
        for (int i = 0; i < 8; i++) step("R2", 0, 1, i, i + 1, i, 7 - i, 0, 0, 0, 0);
        step("R7", 1, 1, 4, 12, 4, 5, 1, 5, 0, 0);
        for (int i = 0; i < 8; i += 2) begin
            idle_read("R7", i, i + 1);
            chk("R7 kind", int'(src0_kind), 0);
        end
        // R1: long pseudo-random sweep against the bench model
        lf = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step("R1", (lf[9:0] == 10'd7), lf[0], int'(lf[3:1]),
                 int'(lf[7:4] | 4'd1), int'(lf[10:8]), int'(lf[13:11]),
                 lf[14], int'(lf[11:8]), lf[15] & lf[2], int'(lf[6:3]));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule